// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Sequencer

This block is the byte-wide register front end of one eight-line programmable interrupt controller channel. Software reaches it through a write strobe, a read strobe, a one-bit address and a data byte. A write to address 0 is either an initialization start or an operation command. A write to address 1 is either a mask load or the next word of an initialization sequence that is in progress. The block keeps the request, in-service and mask registers, the rotating priority base, the vector base and the mode flags. It presents them as outputs to the priority resolver beside it.

The resolver reports each accepted interrupt through an acknowledge strobe and a line number. On that strobe the block marks the line in service, and it retires the line at once when automatic end-of-interrupt is on. Request bits come in through a set-pulse input that is already edge- or level-qualified upstream, and a per-line level-mode input. The block also answers poll reads itself. It picks the winning line with the same rotating priority that the resolver uses. All state changes on the rising clock edge in the cycle a strobe is sampled. Read data is registered and is valid in the cycle after the read strobe.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset, all registers, the priority base, the vector base, the init phase and every mode flag are zero, and reads of both addresses return 0.
- R2: A write to address 0 with bit 4 set clears request, in-service, mask, priority base, vector base and all mode flags. It records bit 0 as the four-word flag and moves init_phase to 1 (0 idle, 1 awaiting vector, 2 awaiting third word, 3 awaiting fourth word).
- R3: In phase 1 an address-1 write stores bits 7:3 as the vector base and moves to phase 2. In phase 2 the next write returns to phase 0, or to phase 3 when the four-word flag is set. In phase 3 a write sets nested mode from bit 4 and automatic end-of-interrupt from bit 1, then returns to phase 0. None of these writes touches the mask.
- R4: An address-1 write in phase 0 loads the byte into the mask register.
- R5: A non-poll read returns the request register at address 0 by default. It returns the in-service register at address 0 after a command with bits 4:3 = 01 and bit 1 set selects it by bit 0 = 1. It returns the mask register at address 1. The value appears on rd_data one cycle after the strobe.
- R6: An acknowledge sets the in-service bit of the acknowledged line. It clears that line's request bit only when the line's level_mode bit is 0.
- R7: With automatic end-of-interrupt on, an acknowledge leaves the line's in-service bit clear. If rotate-on-auto-EOI is also on, the priority base becomes line+1 (mod 8).
- R8: Command code 1 (bits 7:5 = 001, bits 4:3 = 00) clears the in-service bit of highest priority, where priority runs upward from the base line and wraps. Code 5 does the same and also sets the base to that line+1. Neither acts when no in-service bit is set.
- R9: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the base to that line+1.
- R10: Code 6 sets the base to bits 2:0 plus 1. Codes 0 and 4 set rotate-on-auto-EOI to 0 and 1. Code 2 changes nothing.
- R11: A command with bits 4:3 = 01 and bit 2 set arms a poll. The next read returns the winning line number, or 7 when none wins, and clears the winner's request and in-service bits. The poll is disarmed after that single read.
- R12: A command with bits 4:3 = 01 and bit 6 set loads the special-mask flag from bit 5. With bit 6 clear the flag is unchanged.
- R13: A poll winner is the highest-priority unmasked request. It wins only when its priority is strictly higher than the highest in-service line. With special mask on, in-service lines that are masked are left out of that comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data byte |
| ack | input | 1 | Acknowledge strobe from the resolver |
| ack_line | input | 3 | Line being acknowledged |
| req_set | input | 8 | One-cycle request set pulses per line |
| level_mode | input | 8 | Per-line level-sensitive flag |
| rd_data | output | 8 | Registered read data |
| req_reg | output | 8 | Request register |
| isr_reg | output | 8 | In-service register |
| mask_reg | output | 8 | Mask register |
| prio_base | output | 3 | Line holding the highest priority |
| vec_base | output | 5 | Vector base (upper five bits of vector) |
| init_phase | output | 2 | Initialization phase |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_auto_eoi | output | 1 | Rotate-on-auto-EOI flag |
| nested_mode | output | 1 | Fully nested mode flag |
| special_mask | output | 1 | Special-mask flag |

## Verification
The bench sweeps every priority base against every non-empty in-service pattern for the two non-specific end-of-interrupt codes. A design that searches from line 0 instead of the base, or that rotates to the wrong line, would leave the wrong bit set or a wrong base. A poll sweep crosses bases, request, in-service and mask patterns with special mask on and off. It exposes a winner chosen without the strict in-service comparison, or one that ignores masked in-service lines, and a poll flag that survives past one read. Every line is acknowledged under edge and level mode, with and without automatic end-of-interrupt and rotation, which catches a request cleared on a level line or an in-service bit left set. Directed sequences cover the init phase walk, which would corrupt the mask if data words leaked into it, the named end-of-interrupt codes and the special-mask enable bit.

// File: rtl/pic_cmd_pkg.sv
// Package: shared widths and types for the interrupt command sequencer.
// Assumes one channel of eight lines addressed by a byte-wide data bus.
package pic_cmd_pkg;

    localparam int PIC_LINES = 8;                  // interrupt lines per channel
    localparam int PIC_LW    = $clog2(PIC_LINES);  // line number width
    localparam int PIC_DW    = PIC_LINES;          // data byte width
    localparam int PIC_VW    = PIC_DW - PIC_LW;    // vector base width

    // initialization phase, encoding visible on the init_phase port
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_VEC  = 2'd1,
        PH_W3   = 2'd2,
        PH_W4   = 2'd3
    } init_phase_e;

    // one decoded register write
    typedef struct packed {
        logic              start_init;  // address 0, bit 4 set
        logic              need4;       // fourth init word requested
        logic              poll_req;    // arm a poll
        logic              sel_wr;      // update read-back select
        logic              sel_isr;     // new select value
        logic              smm_wr;      // update special mask
        logic              smm_val;     // new special mask value
        logic              eoi_top;     // clear highest in-service bit
        logic              eoi_named;   // clear named in-service bit
        logic              rotate_after;// base follows the cleared line
        logic              base_set;    // base = line + 1
        logic              raeoi_wr;    // update rotate-on-auto-EOI
        logic              raeoi_val;   // new rotate-on-auto-EOI value
        logic              data_wr;     // address-1 write
        logic [PIC_LW-1:0] line;        // line field of the byte
    } wcmd_t;

endpackage

// File: rtl/pic_prio_pick.sv
// Module: rotating priority picker.
// Finds the set bit of highest priority in a line vector. Priority starts at
// line 'base' and falls as the line number rises, wrapping past the top line.
// Assumes NLINES is a power of two so that line arithmetic wraps naturally.
module pic_prio_pick #(
    parameter int NLINES = 8,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    input  logic [LW-1:0]     base,
    output logic              found,
    output logic [LW-1:0]     line
);

    logic [LW-1:0] idx;

    // scan from lowest priority to highest so the last hit is the winner
    always_comb begin
        found = 1'b0;
        line  = '0;
        idx   = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            idx = base + LW'(i);
            if (vec[idx]) begin
                found = 1'b1;
                line  = idx;
            end
        end
    end

endmodule

// File: rtl/pic_wr_decode.sv
// Module: register write decoder.
// Turns a write strobe, address bit and data byte into one command word.
// Purely combinational; the caller applies the effects at the clock edge.
module pic_wr_decode
    import pic_cmd_pkg::*;
(
    input  logic              wr_en,
    input  logic              addr,
    input  logic [PIC_DW-1:0] wdata,
    output wcmd_t             cmd
);

    logic [2:0] code;
    logic       ctl_wr;
    logic       ocw_misc;
    logic       ocw_code;

    assign code     = wdata[7:5];
    assign ctl_wr   = wr_en && !addr;
    assign ocw_misc = ctl_wr && !wdata[4] && wdata[3];
    assign ocw_code = ctl_wr && !wdata[4] && !wdata[3];

    // classify the write and split out its fields
    always_comb begin
        cmd              = '0;
        cmd.line         = wdata[PIC_LW-1:0];
        cmd.start_init   = ctl_wr && wdata[4];
        cmd.need4        = wdata[0];
        cmd.data_wr      = wr_en && addr;
        cmd.poll_req     = ocw_misc && wdata[2];
        cmd.sel_wr       = ocw_misc && wdata[1];
        cmd.sel_isr      = wdata[0];
        cmd.smm_wr       = ocw_misc && wdata[6];
        cmd.smm_val      = wdata[5];
        if (ocw_code) begin
            case (code)
                3'd0, 3'd4: begin
                    cmd.raeoi_wr  = 1'b1;
                    cmd.raeoi_val = code[2];
                end
                3'd1: cmd.eoi_top = 1'b1;
                3'd5: begin
                    cmd.eoi_top      = 1'b1;
                    cmd.rotate_after = 1'b1;
                end
                3'd3: cmd.eoi_named = 1'b1;
                3'd7: begin
                    cmd.eoi_named    = 1'b1;
                    cmd.rotate_after = 1'b1;
                end
                3'd6: cmd.base_set = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pic_cmd_seq.sv
// Module: interrupt controller command and initialization sequencer (top).
// Holds the request, in-service and mask registers, the priority base, the
// vector base and mode flags of one channel. It decodes register writes, serves
// register and poll reads, and applies acknowledges from the resolver.
// Assumes one strobe kind per cycle in normal use. When several coincide, an
// initialization start overrides everything else in that cycle.
module pic_cmd_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [PIC_DW-1:0] wdata,
    input  logic              ack,
    input  logic [PIC_LW-1:0] ack_line,
    input  logic [PIC_LINES-1:0] req_set,
    input  logic [PIC_LINES-1:0] level_mode,
    output logic [PIC_DW-1:0] rd_data,
    output logic [PIC_LINES-1:0] req_reg,
    output logic [PIC_LINES-1:0] isr_reg,
    output logic [PIC_LINES-1:0] mask_reg,
    output logic [PIC_LW-1:0] prio_base,
    output logic [PIC_VW-1:0] vec_base,
    output logic [1:0]        init_phase,
    output logic              auto_eoi,
    output logic              rot_auto_eoi,
    output logic              nested_mode,
    output logic              special_mask
);

    localparam logic [PIC_LW-1:0] ONE_L   = PIC_LW'(1);
    localparam logic [PIC_DW-1:0] NO_WIN  = PIC_DW'(PIC_LINES - 1);

    // registered state
    logic [PIC_LINES-1:0] req_q, isr_q, mask_q;
    logic [PIC_LW-1:0]    base_q;
    logic [PIC_VW-1:0]    vec_q;
    init_phase_e          phase_q;
    logic                 need4_q, aeoi_q, raeoi_q, nested_q, smm_q;
    logic                 poll_q, sel_q;
    logic [PIC_DW-1:0]    rdata_q;

    // next state
    logic [PIC_LINES-1:0] req_n, isr_n, mask_n;
    logic [PIC_LW-1:0]    base_n;
    logic [PIC_VW-1:0]    vec_n;
    init_phase_e          phase_n;
    logic                 need4_n, aeoi_n, raeoi_n, nested_n, smm_n;
    logic                 poll_n, sel_n;
    logic [PIC_DW-1:0]    rdata_n;

    wcmd_t                cmd;

    // priority picks: pending, in-service seen by poll, in-service for EOI
    logic [PIC_LINES-1:0] pend_vec, cur_vec;
    logic                 pend_found, cur_found, top_found;
    logic [PIC_LW-1:0]    pend_line, cur_line, top_line;
    logic [PIC_LW-1:0]    pend_rank, cur_rank;
    logic                 poll_win;

    pic_wr_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    assign pend_vec = req_q & ~mask_q;
    assign cur_vec  = smm_q ? (isr_q & ~mask_q) : isr_q;

    pic_prio_pick #(.NLINES(PIC_LINES)) u_pick_pend (
        .vec (pend_vec), .base (base_q), .found (pend_found), .line (pend_line)
    );
    pic_prio_pick #(.NLINES(PIC_LINES)) u_pick_cur (
        .vec (cur_vec), .base (base_q), .found (cur_found), .line (cur_line)
    );
    pic_prio_pick #(.NLINES(PIC_LINES)) u_pick_top (
        .vec (isr_q), .base (base_q), .found (top_found), .line (top_line)
    );

    // distance from the base; a smaller rank is a higher priority
    assign pend_rank = pend_line - base_q;
    assign cur_rank  = cur_line - base_q;
    assign poll_win  = pend_found && (!cur_found || (pend_rank < cur_rank));

    // combine every event of the cycle into the next register state
    always_comb begin
        req_n    = req_q | req_set;
        isr_n    = isr_q;
        mask_n   = mask_q;
        base_n   = base_q;
        vec_n    = vec_q;
        phase_n  = phase_q;
        need4_n  = need4_q;
        aeoi_n   = aeoi_q;
        raeoi_n  = raeoi_q;
        nested_n = nested_q;
        smm_n    = smm_q;
        poll_n   = poll_q;
        sel_n    = sel_q;
        rdata_n  = rdata_q;

        if (cmd.data_wr) begin
            case (phase_q)
                PH_IDLE: mask_n = wdata;
                PH_VEC: begin
                    vec_n   = wdata[PIC_DW-1:PIC_LW];
                    phase_n = PH_W3;
                end
                PH_W3:   phase_n = need4_q ? PH_W4 : PH_IDLE;
                PH_W4: begin
                    nested_n = wdata[4];
                    aeoi_n   = wdata[1];
                    phase_n  = PH_IDLE;
                end
                default: phase_n = PH_IDLE;
            endcase
        end

        if (cmd.poll_req) poll_n  = 1'b1;
        if (cmd.sel_wr)   sel_n   = cmd.sel_isr;
        if (cmd.smm_wr)   smm_n   = cmd.smm_val;
        if (cmd.raeoi_wr) raeoi_n = cmd.raeoi_val;

        if (cmd.eoi_top && top_found) begin
            isr_n[top_line] = 1'b0;
            if (cmd.rotate_after) base_n = top_line + ONE_L;
        end
        if (cmd.eoi_named) begin
            isr_n[cmd.line] = 1'b0;
            if (cmd.rotate_after) base_n = cmd.line + ONE_L;
        end
        if (cmd.base_set) base_n = cmd.line + ONE_L;

        if (ack) begin
            isr_n[ack_line] = 1'b1;
            if (!level_mode[ack_line]) req_n[ack_line] = 1'b0;
            if (aeoi_q) begin
                isr_n[ack_line] = 1'b0;
                if (raeoi_q) base_n = ack_line + ONE_L;
            end
        end

        if (rd_en) begin
            if (poll_q) begin
                poll_n = 1'b0;
                if (poll_win) begin
                    rdata_n          = {{(PIC_DW-PIC_LW){1'b0}}, pend_line};
                    req_n[pend_line] = 1'b0;
                    isr_n[pend_line] = 1'b0;
                end else begin
                    rdata_n = NO_WIN;
                end
            end else if (addr) begin
                rdata_n = mask_q;
            end else begin
                rdata_n = sel_q ? isr_q : req_q;
            end
        end

        if (cmd.start_init) begin
            req_n    = '0;
            isr_n    = '0;
            mask_n   = '0;
            base_n   = '0;
            vec_n    = '0;
            aeoi_n   = 1'b0;
            raeoi_n  = 1'b0;
            nested_n = 1'b0;
            smm_n    = 1'b0;
            poll_n   = 1'b0;
            sel_n    = 1'b0;
            need4_n  = cmd.need4;
            phase_n  = PH_VEC;
        end
    end

    // state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= '0;
            isr_q    <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            vec_q    <= '0;
            phase_q  <= PH_IDLE;
            need4_q  <= 1'b0;
            aeoi_q   <= 1'b0;
            raeoi_q  <= 1'b0;
            nested_q <= 1'b0;
            smm_q    <= 1'b0;
            poll_q   <= 1'b0;
            sel_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            req_q    <= req_n;
            isr_q    <= isr_n;
            mask_q   <= mask_n;
            base_q   <= base_n;
            vec_q    <= vec_n;
            phase_q  <= phase_n;
            need4_q  <= need4_n;
            aeoi_q   <= aeoi_n;
            raeoi_q  <= raeoi_n;
            nested_q <= nested_n;
            smm_q    <= smm_n;
            poll_q   <= poll_n;
            sel_q    <= sel_n;
            rdata_q  <= rdata_n;
        end
    end

    assign rd_data      = rdata_q;
    assign req_reg      = req_q;
    assign isr_reg      = isr_q;
    assign mask_reg     = mask_q;
    assign prio_base    = base_q;
    assign vec_base     = vec_q;
    assign init_phase   = phase_q;
    assign auto_eoi     = aeoi_q;
    assign rot_auto_eoi = raeoi_q;
    assign nested_mode  = nested_q;
    assign special_mask = smm_q;

endmodule

// File: rtl/pic_cmd_seq_chk.sv
// Module: property checker for the command sequencer, bound to every instance.
// Observes ports and the poll flag; drives nothing.
module pic_cmd_seq_chk
    import pic_cmd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic                 addr,
    input logic [PIC_DW-1:0]    wdata,
    input logic                 ack,
    input logic [PIC_LW-1:0]    ack_line,
    input logic [PIC_LINES-1:0] level_mode,
    input logic [PIC_LINES-1:0] req_reg,
    input logic [PIC_LINES-1:0] isr_reg,
    input logic [PIC_LINES-1:0] mask_reg,
    input logic [PIC_LW-1:0]    prio_base,
    input logic [PIC_VW-1:0]    vec_base,
    input logic [1:0]           init_phase,
    input logic                 auto_eoi,
    input logic                 poll_q
);

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=>
        (req_reg == '0 && isr_reg == '0 && mask_reg == '0 && prio_base == '0
         && init_phase == 2'd1 && !auto_eoi));

    // R3
    vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && init_phase == 2'd1) |=>
        (vec_base == $past(wdata[PIC_DW-1:PIC_LW]) && init_phase == 2'd2
         && $stable(mask_reg)));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && init_phase == 2'd0) |=> (mask_reg == $past(wdata)));

    // R6
    ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !auto_eoi && !wr_en && !rd_en) |=> isr_reg[$past(ack_line)]);

    // R6
    level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && level_mode[ack_line] && !wr_en && !rd_en) |=> req_reg[$past(ack_line)]);

    // R7
    aeoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && !wr_en && !rd_en) |=> !isr_reg[$past(ack_line)]);

    // R11
    poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q && !wr_en) |=> !poll_q);

endmodule

bind pic_cmd_seq pic_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .ack        (ack),
    .ack_line   (ack_line),
    .level_mode (level_mode),
    .req_reg    (req_reg),
    .isr_reg    (isr_reg),
    .mask_reg   (mask_reg),
    .prio_base  (prio_base),
    .vec_base   (vec_base),
    .init_phase (init_phase),
    .auto_eoi   (auto_eoi),
    .poll_q     (poll_q)
);

// File: tb/sim_pic_cmd_seq.sv
// Bench: sweeps end-of-interrupt, poll and acknowledge behaviour against an
// arithmetic model of rotating priority; inputs change on the falling edge.
module sim_pic_cmd_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] ack_line = '0;
    logic [7:0] req_set = '0, level_mode = '0;
    logic [7:0] rd_data, req_reg, isr_reg, mask_reg;
    logic [2:0] prio_base;
    logic [4:0] vec_base;
    logic [1:0] init_phase;
    logic       auto_eoi, rot_auto_eoi, nested_mode, special_mask;

    int ntest = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ack(ack), .ack_line(ack_line), .req_set(req_set),
        .level_mode(level_mode), .rd_data(rd_data), .req_reg(req_reg),
        .isr_reg(isr_reg), .mask_reg(mask_reg), .prio_base(prio_base),
        .vec_base(vec_base), .init_phase(init_phase), .auto_eoi(auto_eoi),
        .rot_auto_eoi(rot_auto_eoi), .nested_mode(nested_mode),
        .special_mask(special_mask)
    );

    task automatic chk(input string rq, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic do_ack(input int l);
        @(negedge clk); ack = 1'b1; ack_line = 3'(l);
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_req(input logic [7:0] r);
        @(negedge clk); req_set = r;
        @(negedge clk); req_set = '0;
    endtask

    task automatic do_init(input logic four, input logic [7:0] w4);
        wr(1'b0, 8'h10 | {7'd0, four});
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        if (four) wr(1'b1, w4);
    endtask

    task automatic load_isr(input logic [7:0] s);
        for (int i = 0; i < 8; i++) if (s[i]) do_ack(i);
    endtask

    function automatic int pick(input logic [7:0] m, input int b);
        for (int i = 0; i < 8; i++) if (m[(b + i) % 8]) return (b + i) % 8;
        return 8;
    endfunction

    function automatic int rank(input int l, input int b);
        return (l - b + 8) % 8;
    endfunction

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 req", req_reg, 0); chk("R1 isr", isr_reg, 0);
        chk("R1 mask", mask_reg, 0); chk("R1 base", prio_base, 0);
        chk("R1 vec", vec_base, 0); chk("R1 phase", init_phase, 0);
        chk("R1 flags", {auto_eoi, rot_auto_eoi, nested_mode, special_mask}, 0);
        rd(1'b0, d); chk("R1 read0", d, 0);
        rd(1'b1, d); chk("R1 read1", d, 0);

        // R4 and R5 mask load and read-back
        wr(1'b1, 8'h3C); chk("R4 mask", mask_reg, 8'h3C);
        rd(1'b1, d); chk("R5 read mask", d, 8'h3C);
        set_req(8'h81); rd(1'b0, d); chk("R5 read req", d, 8'h81);
        do_ack(3); wr(1'b0, 8'h0B); rd(1'b0, d); chk("R5 read isr", d, 8'h08);
        wr(1'b0, 8'h0A); rd(1'b0, d); chk("R5 read req again", d, 8'h81);

        // R2 and R3 init walk
        wr(1'b0, 8'h11);
        chk("R2 req", req_reg, 0); chk("R2 isr", isr_reg, 0);
        chk("R2 mask", mask_reg, 0); chk("R2 phase", init_phase, 1);
        wr(1'b1, 8'hA5);
        chk("R3 vec", vec_base, 8'hA5 >> 3); chk("R3 phase2", init_phase, 2);
        chk("R3 mask kept", mask_reg, 0);
        wr(1'b1, 8'hFF); chk("R3 phase3", init_phase, 3);
        chk("R3 mask kept w3", mask_reg, 0);
        wr(1'b1, 8'h12);
        chk("R3 nested", nested_mode, 1); chk("R3 aeoi", auto_eoi, 1);
        chk("R3 idle", init_phase, 0); chk("R3 mask kept w4", mask_reg, 0);
        wr(1'b1, 8'h0F); chk("R4 mask after init", mask_reg, 8'h0F);
        wr(1'b0, 8'h10); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
        chk("R3 three-word end", init_phase, 0);
        chk("R2 aeoi cleared", auto_eoi, 0);

        // R9 named end-of-interrupt
        load_isr(8'hFF);
        wr(1'b0, 8'h63); chk("R9 code3 isr", isr_reg, 8'hF7); chk("R9 code3 base", prio_base, 0);
        wr(1'b0, 8'hE5); chk("R9 code7 isr", isr_reg, 8'hD7); chk("R9 code7 base", prio_base, 6);

        // R10 base set, rotate flag, no-op
        wr(1'b0, 8'hC2); chk("R10 code6 base", prio_base, 3);
        wr(1'b0, 8'h80); chk("R10 code4 flag", rot_auto_eoi, 1);
        wr(1'b0, 8'h00); chk("R10 code0 flag", rot_auto_eoi, 0);
        wr(1'b0, 8'h40); chk("R10 code2 isr", isr_reg, 8'hD7); chk("R10 code2 base", prio_base, 3);

        // R12 special mask enable bit
        wr(1'b0, 8'h68); chk("R12 set", special_mask, 1);
        wr(1'b0, 8'h28); chk("R12 no enable", special_mask, 1);
        wr(1'b0, 8'h48); chk("R12 clear", special_mask, 0);

        // R8 sweep every base against every in-service pattern
        for (int b = 0; b < 8; b++) begin
            for (int p = 1; p < 256; p++) begin
                bit rot5;
                int w;
                rot5 = p[0];
                do_init(1'b0, 8'h00);
                wr(1'b0, 8'hC0 | 8'((b + 7) % 8));
                load_isr(8'(p));
                wr(1'b0, rot5 ? 8'hA0 : 8'h20);
                w = pick(8'(p), b);
                chk("R8 eoi isr", isr_reg, p & ~(1 << w));
                chk("R8 eoi base", prio_base, rot5 ? (w + 1) % 8 : b);
            end
        end

        // R11 and R13 poll sweep
        for (int b = 0; b < 8; b++) begin
            for (int sm = 0; sm < 2; sm++) begin
                for (int s = 0; s < 256; s += 51) begin
                    for (int r = 0; r < 256; r += 7) begin
                        logic [7:0] m, cm;
                        int pw, cw, exp_line;
                        bit win;
                        m = 8'((r * 37 + s) & 8'h93);
                        do_init(1'b0, 8'h00);
                        wr(1'b0, 8'hC0 | 8'((b + 7) % 8));
                        load_isr(8'(s));
                        set_req(8'(r));
                        wr(1'b1, m);
                        if (sm != 0) wr(1'b0, 8'h68);
                        wr(1'b0, 8'h0C);
                        rd(1'b0, d);
                        pw = pick(8'(r) & ~m, b);
                        cm = (sm != 0) ? (8'(s) & ~m) : 8'(s);
                        cw = pick(cm, b);
                        win = (pw != 8) && ((cw == 8) || (rank(pw, b) < rank(cw, b)));
                        exp_line = win ? pw : 7;
                        chk("R13 poll winner", d, exp_line);
                        chk("R11 poll req", req_reg, win ? (r & ~(1 << pw)) : r);
                        chk("R11 poll isr", isr_reg, win ? (s & ~(1 << pw)) : s);
                        rd(1'b1, d);
                        chk("R11 poll one-shot", d, m);
                    end
                end
            end
        end

        // R6 and R7 acknowledge sweep
        for (int l = 0; l < 8; l++) begin
            for (int lv = 0; lv < 2; lv++) begin
                for (int mode = 0; mode < 3; mode++) begin
                    do_init(mode != 0, 8'h02);
                    if (mode == 2) wr(1'b0, 8'h80);
                    level_mode = (lv != 0) ? 8'(1 << l) : 8'h00;
                    set_req(8'(1 << l));
                    do_ack(l);
                    chk("R6 req after ack", req_reg[l], lv);
                    chk("R7 isr after ack", isr_reg[l], (mode == 0) ? 1 : 0);
                    chk("R7 base after ack", prio_base, (mode == 2) ? (l + 1) % 8 : 0);
                    level_mode = '0;
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

endmodule